// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a pulse-width modulator channel. The module clock feeds two prescaler stages in a chain. From them comes a single-cycle step enable. On every step a 16-bit counter moves according to the selected count mode, checking against an active period value. The block issues a one-clock zero strobe whenever the count takes the value 0. It issues a one-clock period strobe whenever the count takes the active period value. Compare logic and waveform generation downstream use these strobes, together with the live count and direction outputs.

A two-address write port sets the configuration. Address 0 holds the control word and address 1 holds the period. The period can be buffered until the next zero or applied at once. A debug halt input, combined with the run-mode field, lets the counter stop right after its next step, stop at the end of the running cycle, or ignore halt entirely.

Control word layout: bits [1:0] count mode (0 up, 1 down, 2 up-down, 3 hold), bit [2] immediate period load, bits [5:3] first-stage exponent, bits [8:6] second-stage factor, bits [10:9] run mode (0 stop after next step, 1 stop at end of cycle, 2 or 3 free running).

Top module: `pwm_timebase`

## Requirements
- R1: While reset is high the count is 0, the direction output is 1, and both strobes are 0.
- R2: In up mode (mode 0) the count steps up by one per step and goes to 0 from the period value. zero_evt is high exactly on steps that make the count 0, and prd_evt exactly on steps that make it equal to the period.
- R3: In down mode (mode 1) the count steps down by one per step and reloads the period value from 0. The direction output is 0.
- R4: In up-down mode (mode 2) the count rises to the period value and then falls to 0. The direction output gives the direction of the step that produced the current count. It turns to 0 on leaving the period value and to 1 on leaving 0.
- R5: In hold mode (mode 3) the count does not change and neither strobe fires.
- R6: Steps occur every 2^a * (b == 0 ? 1 : 2*b) module clocks, where a is the first-stage field and b the second-stage field.
- R7: A new prescaler setting takes effect at the step after the write. The old interval finishes first, and the interval after that uses the new ratio.
- R8: With control bit 2 at 0, a period write is held in a shadow register. It becomes active on the step that makes the count 0.
- R9: With control bit 2 at 1, a period write becomes active on the clock edge of the write.
- R10: In run mode 0, asserting halt lets exactly one more step happen and then holds the count. Releasing halt resumes counting after one clock.
- R11: In run mode 1, asserting halt lets counting continue until the count becomes 0, and then holds it there.
- R12: In run mode 2 or 3, halt has no effect on counting.
- R13: The count changes only on clocks where the prescaler issues a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 the period |
| wr_data | input | 16 | Write data |
| halt | input | 1 | Debug halt request, interpreted by run mode |
| count | output | 16 | Current counter value |
| count_up | output | 1 | 1 when the last step counted up |
| zero_evt | output | 1 | One-clock strobe when the count becomes 0 |
| prd_evt | output | 1 | One-clock strobe when the count becomes the period |

## Verification
The assertions assume that wr_data and halt are synchronous to clk and carry known values whenever they are sampled. They also assume that reset lasts at least one edge, so that the period and prescaler registers start from zero. The bench changes every input only on the falling clock edge and writes only defined words. It places period writes at chosen count values, so the shadow and immediate loads each meet a known count and no period is changed mid-step.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_A_W = 3;
  localparam int PRE_B_W = 3;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RUN_STEP   = 2'd0,
    RUN_CYCLE  = 2'd1,
    RUN_FREE_A = 2'd2,
    RUN_FREE   = 2'd3
  } run_mode_e;

  typedef struct packed {
    logic [4:0]         rsvd;
    run_mode_e          run;
    logic [PRE_B_W-1:0] pre_b;
    logic [PRE_A_W-1:0] pre_a;
    logic               prd_imm;
    cnt_mode_e          mode;
  } tb_ctl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int A_W = 3,
  parameter int B_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] pre_a,
  input  logic [B_W-1:0] pre_b,
  output logic           tick
);
  localparam int CA_W = (1 << A_W) - 1;
  localparam int CB_W = B_W + 1;

  logic [A_W-1:0]  a_act;
  logic [B_W-1:0]  b_act;
  logic [CA_W-1:0] cnt_a, lim_a;
  logic [CB_W-1:0] cnt_b, lim_b;
  logic            tick_a;

  always_comb begin
    lim_a  = (CA_W'(1) << a_act) - CA_W'(1);
    lim_b  = (b_act == '0) ? '0 : (CB_W'({b_act, 1'b0}) - CB_W'(1));
    tick_a = (cnt_a == lim_a);
    tick   = tick_a && (cnt_b == lim_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a <= '0;
      cnt_b <= '0;
      a_act <= '0;
      b_act <= '0;
    end else if (tick) begin
      cnt_a <= '0;
      cnt_b <= '0;
      a_act <= pre_a;
      b_act <= pre_b;
    end else if (tick_a) begin
      cnt_a <= '0;
      cnt_b <= cnt_b + CB_W'(1);
    end else begin
      cnt_a <= cnt_a + CA_W'(1);
    end
  end
endmodule

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         imm,
  input  logic         load,
  output logic [W-1:0] prd
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      prd    <= '0;
    end else begin
      if (wr_en) shadow <= wr_data;
      if (wr_en && imm) prd <= wr_data;
      else if (load)    prd <= shadow;
    end
  end

  // R9
  prd_imm_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && imm) |=> (prd == $past(wr_data)));

  // R8
  prd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !(wr_en && imm)) |=> $stable(prd));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_timebase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  cnt_mode_e    mode,
  input  run_mode_e    run,
  input  logic         halt,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         zero_evt,
  output logic         prd_evt,
  output logic         reach_zero
);
  logic         stopped;
  logic         adv;
  logic [W-1:0] nxt;
  logic         nxt_up;

  always_comb begin
    adv    = step && !stopped && (mode != CM_HOLD);
    nxt    = cnt;
    nxt_up = up;
    case (mode)
      CM_UP: begin
        nxt    = (cnt >= prd) ? '0 : cnt + W'(1);
        nxt_up = 1'b1;
      end
      CM_DOWN: begin
        nxt    = (cnt == '0 || cnt > prd) ? prd : cnt - W'(1);
        nxt_up = 1'b0;
      end
      CM_UPDOWN: begin
        if (up) begin
          if (cnt >= prd) begin
            nxt    = (cnt == '0) ? '0 : cnt - W'(1);
            nxt_up = 1'b0;
          end else begin
            nxt = cnt + W'(1);
          end
        end else begin
          if (cnt == '0) begin
            nxt    = (prd == '0) ? '0 : W'(1);
            nxt_up = 1'b1;
          end else begin
            nxt = cnt - W'(1);
          end
        end
      end
      default: ;
    endcase
    reach_zero = adv && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      up       <= 1'b1;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
      stopped  <= 1'b0;
    end else begin
      zero_evt <= reach_zero;
      prd_evt  <= adv && (nxt == prd);
      if (adv) begin
        cnt <= nxt;
        up  <= nxt_up;
      end
      if (!halt)
        stopped <= 1'b0;
      else if (adv && (run == RUN_STEP || (run == RUN_CYCLE && nxt == '0)))
        stopped <= 1'b1;
    end
  end

  // R13
  step_only_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));

  // R2
  up_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !stopped && mode == CM_UP && cnt < prd) |=> (cnt == $past(cnt) + W'(1)));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stopped && halt) |=> $stable(cnt));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [15:0]  wr_data,
  input  logic         halt,
  output logic [W-1:0] count,
  output logic         count_up,
  output logic         zero_evt,
  output logic         prd_evt
);
  tb_ctl_t      ctl_q;
  logic         tick;
  logic         reach_zero;
  logic [W-1:0] prd;

  always_ff @(posedge clk) begin
    if (rst)                    ctl_q <= '0;
    else if (wr_en && !wr_addr) ctl_q <= tb_ctl_t'(wr_data);
  end

  pwm_prescaler #(.A_W(PRE_A_W), .B_W(PRE_B_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .pre_a (ctl_q.pre_a),
    .pre_b (ctl_q.pre_b),
    .tick  (tick)
  );

  pwm_period_reg #(.W(W)) u_prd (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && wr_addr),
    .wr_data (W'(wr_data)),
    .imm     (ctl_q.prd_imm),
    .load    (reach_zero),
    .prd     (prd)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (tick),
    .mode       (ctl_q.mode),
    .run        (ctl_q.run),
    .halt       (halt),
    .prd        (prd),
    .cnt        (count),
    .up         (count_up),
    .zero_evt   (zero_evt),
    .prd_evt    (prd_evt),
    .reach_zero (reach_zero)
  );
endmodule

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        halt = 1'b0;
  logic [15:0] count;
  logic        count_up, zero_evt, prd_evt;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .halt(halt), .count(count), .count_up(count_up), .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  // prescaler vectors: {first stage a, second stage b, expected clocks per step}
  localparam logic [16:0] PV [0:5] = '{
    {3'd0, 3'd0, 11'd1},   {3'd1, 3'd0, 11'd2},  {3'd0, 3'd1, 11'd2},
    {3'd2, 3'd3, 11'd24},  {3'd3, 3'd2, 11'd32}, {3'd7, 3'd7, 11'd1792}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int mode, input int imm, input int a,
                                     input int b, input int run);
    return {5'b0, 2'(run), 3'(b), 3'(a), 1'(imm), 2'(mode)};
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic interval(output int n);
    logic [15:0] prev;
    prev = count;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (count == prev && n < 4000);
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    while (int'(count) != v && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // follows the counting rules of R2, R3, R4 sample by sample
  task automatic seq_check(input int mode, input int p, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int pc, pd, ec, ed;
      pc = int'(count);
      pd = int'(count_up);
      @(negedge clk);
      if (mode == 0) begin
        ec = (pc >= p) ? 0 : pc + 1; ed = 1;
      end else if (mode == 1) begin
        ec = (pc == 0 || pc > p) ? p : pc - 1; ed = 0;
      end else if (pd == 1) begin
        if (pc >= p) begin ec = (pc == 0) ? 0 : pc - 1; ed = 0; end
        else begin ec = pc + 1; ed = 1; end
      end else begin
        if (pc == 0) begin ec = (p == 0) ? 0 : 1; ed = 1; end
        else begin ec = pc - 1; ed = 0; end
      end
      chk(int'(count) == ec && int'(count_up) == ed, req, int'(count) * 2 + int'(count_up), ec * 2 + ed);
      chk(zero_evt == (count == 0) && prd_evt == (int'(count) == p), req,
          {zero_evt, prd_evt}, {(count == 0), (int'(count) == p)});
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, e, pe;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count", int'(count), 0);
    chk(count_up == 1'b1, "R1 dir", int'(count_up), 1);
    chk(!zero_evt && !prd_evt, "R1 strobes", {zero_evt, prd_evt}, 0);
    rst = 1'b0;

    // R6 table of prescaler ratios
    for (int v = 0; v < 6; v++) begin
      wr(1'b0, mk(0, 1, int'(PV[v][16:14]), int'(PV[v][13:11]), 3));
      wr(1'b1, 16'd1000);
      interval(n); interval(n); interval(n);
      chk(n == int'(PV[v][10:0]), "R6 step interval", n, int'(PV[v][10:0]));
    end

    // R7 ratio change waits for the running interval
    wr(1'b0, mk(0, 1, 0, 0, 3));
    interval(n);
    chk(n <= 1793, "R7 old interval finishes", n, 1792);
    interval(n);
    chk(n == 1, "R7 new ratio after tick", n, 1);

    // R2 up
    wr(1'b0, mk(0, 1, 0, 0, 3)); wr(1'b1, 16'd5);
    repeat (4) @(negedge clk);
    seq_check(0, 5, 14, "R2 up mode");
    // R3 down
    wr(1'b0, mk(1, 1, 0, 0, 3)); wr(1'b1, 16'd4);
    repeat (4) @(negedge clk);
    seq_check(1, 4, 12, "R3 down mode");
    // R4 up-down
    wr(1'b0, mk(2, 1, 0, 0, 3)); wr(1'b1, 16'd3);
    repeat (4) @(negedge clk);
    seq_check(2, 3, 16, "R4 up-down mode");

    // R5 hold
    wr(1'b0, mk(3, 1, 0, 0, 3));
    repeat (2) @(negedge clk);
    e = int'(count);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(int'(count) == e && !zero_evt && !prd_evt, "R5 hold", int'(count), e);
    end

    // R8 shadow period load at zero
    wr(1'b0, mk(0, 1, 0, 0, 3)); wr(1'b1, 16'd5);
    wr(1'b0, mk(0, 0, 0, 0, 3));
    wait_count(2);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'd9;
    @(negedge clk);
    wr_en = 1'b0;
    e = 3; pe = 5;
    for (int i = 0; i < 16; i++) begin
      chk(int'(count) == e, "R8 shadow load", int'(count), e);
      e = (e >= pe) ? 0 : e + 1;
      if (e == 0) pe = 9;
      @(negedge clk);
    end

    // R9 immediate period load
    wr(1'b0, mk(0, 1, 0, 0, 3)); wr(1'b1, 16'd9);
    wait_count(7);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'd4;
    @(negedge clk);
    wr_en = 1'b0;
    e = 8;
    for (int i = 0; i < 7; i++) begin
      chk(int'(count) == e, "R9 immediate load", int'(count), e);
      e = (e >= 4) ? 0 : e + 1;
      @(negedge clk);
    end

    // R10 stop after next step
    wr(1'b0, mk(0, 1, 0, 0, 0)); wr(1'b1, 16'd9);
    wait_count(3);
    halt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(count == 4, "R10 halted", int'(count), 4);
    end
    chk(!zero_evt && !prd_evt, "R10 no strobes while halted", {zero_evt, prd_evt}, 0);
    halt = 1'b0;
    @(negedge clk);
    chk(count == 4, "R10 release latency", int'(count), 4);
    @(negedge clk);
    chk(count == 5, "R10 resume", int'(count), 5);

    // R11 stop at end of cycle
    wr(1'b0, mk(0, 1, 0, 0, 1));
    wait_count(3);
    halt = 1'b1;
    e = 4;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(int'(count) == e, "R11 run to cycle end", int'(count), e);
      if (e != 0) e = (e >= 9) ? 0 : e + 1;
    end
    halt = 1'b0;
    repeat (2) @(negedge clk);
    chk(count == 1, "R11 resume", int'(count), 1);

    // R12 free running ignores halt
    wr(1'b0, mk(0, 1, 0, 0, 3));
    wait_count(3);
    halt = 1'b1;
    e = 4;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(int'(count) == e, "R12 halt ignored", int'(count), e);
      e = (e >= 9) ? 0 : e + 1;
    end
    halt = 1'b0;

    // R13 count only moves on steps (ratio 4)
    wr(1'b0, mk(0, 1, 2, 0, 3));
    interval(n); interval(n);
    for (int i = 0; i < 3; i++) begin
      e = int'(count);
      @(negedge clk);
      chk(int'(count) == e, "R13 stable between steps", int'(count), e);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule